// File: doc/BRIEF.md
# Redundant Link Load-Sharing Dispatcher with Failover

This block sits between a message source and two redundant time-triggered bus channels. While both channels are healthy it spreads outgoing messages over them in alternation, so each carries about half the load. A channel that is busy (not ready) is passed over in favour of the other one, and the source is held only when neither can take a message.

Each channel is supervised by a watchdog that expects a periodic reference pulse on that channel within a programmable number of clock cycles. When the pulse stays away too long, the channel is marked down, a one-cycle fault pulse is raised for the reconfiguration layer above, and all traffic moves to the surviving channel. Because one channel carries less, only messages tagged urgent are still forwarded; the others are accepted and discarded, and a saturating counter tallies them. If both channels are down, every message is discarded and a total-failure flag is raised. A downed channel comes back only after an explicit recovery request followed by a fresh reference pulse on it.

Top module: `dual_link_dispatch`

## Requirements
- R1: After reset both channels are reported healthy (`link_ok` = 2'b11), `total_fail` and `fail_pulse` are 0, `drop_count` is 0, no channel valid is raised, and the alternation pointer selects channel 0 first.
- R2: With both channels healthy and ready, successive messages go to channel 0, 1, 0, 1, ...; after each forward the pointer selects the channel not just used.
- R3: With both healthy, if the pointed channel is not ready the message goes to the other ready channel; if neither is ready `msg_ready` stays 0 and no channel valid is raised.
- R4: A channel is marked down at the clock edge where `cfg_timeout` consecutive edges have passed since its last reference pulse; reference pulses spaced exactly `cfg_timeout` cycles apart keep it healthy.
- R5: `fail_pulse[i]` is high for exactly one cycle, the first cycle in which `link_ok[i]` reads 0, for each failure event.
- R6: With one channel down, urgent messages are sent only to the surviving channel, waiting for its ready; the downed channel's valid never rises.
- R7: With one channel down, a non-urgent message is accepted at once (`msg_ready` = 1) and sent nowhere.
- R8: With both channels down, `total_fail` is 1 and every message, urgent or not, is accepted and sent nowhere.
- R9: A downed channel returns to service only when a reference pulse on it arrives in a cycle after a `recover_req` pulse for it; reference pulses without a prior request leave it down.
- R10: `drop_count` increments by one for each non-urgent message discarded (R7, R8), not for discarded urgent messages, and saturates at its maximum.
- R11: `ch0_data` and `ch1_data` carry `msg_data` unchanged to whichever channel receives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_timeout | input | TMR_W | Watchdog limit in clock cycles |
| msg_valid | input | 1 | Source offers a message |
| msg_ready | output | 1 | Message taken (forwarded or discarded) this cycle |
| msg_data | input | DATA_W | Message payload |
| msg_urgent | input | 1 | Message may use the single surviving channel |
| ch_valid | output | 2 | Per-channel valid, bit i for channel i |
| ch_ready | input | 2 | Per-channel ready, bit i for channel i |
| ch0_data | output | DATA_W | Payload to channel 0 |
| ch1_data | output | DATA_W | Payload to channel 1 |
| ref_pulse | input | 2 | Reference message seen, bit i for channel i |
| recover_req | input | 2 | Request to readmit channel i |
| link_ok | output | 2 | Channel i healthy |
| fail_pulse | output | 2 | One-cycle report that channel i went down |
| total_fail | output | 1 | Both channels down |
| drop_count | output | CNT_W | Number of discarded non-urgent messages |

## Verification
The bench goes after the alternation pointer across a busy channel and a full stall, where a design that did not advance the pointer from the channel actually used would send two messages in a row to one channel. It spaces reference pulses at exactly the limit, which catches an off-by-one watchdog that declares a healthy channel dead. It feeds reference pulses to a downed channel before any recovery request, exposing a design that readmits on a pulse alone, and it discards urgent messages with both channels gone, which reveals a counter that counts every drop rather than only non-urgent ones.

// File: rtl/dld_pkg.sv
package dld_pkg;

    // Where the offered message goes in the current cycle.
    typedef enum logic [1:0] {
        ROUTE_HOLD = 2'd0,
        ROUTE_CH0  = 2'd1,
        ROUTE_CH1  = 2'd2,
        ROUTE_DROP = 2'd3
    } route_e;

    function automatic route_e route_of(input logic ch);
        return ch ? ROUTE_CH1 : ROUTE_CH0;
    endfunction

endpackage

// File: rtl/dld_watchdog.sv
module dld_watchdog #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] limit,
    input  logic             ref_seen,
    input  logic             recover,
    output logic             down,
    output logic             down_pulse
);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic             down;
        logic             armed;
        logic             pulse;
    } wd_state_t;

    wd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!st_q.down) begin
            if (ref_seen) begin
                st_d.cnt = '0;
            end else if (({1'b0, st_q.cnt} + 1'b1) >= {1'b0, limit}) begin
                st_d.cnt   = '0;
                st_d.down  = 1'b1;
                st_d.armed = 1'b0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            if (st_q.armed && ref_seen) begin
                st_d.down  = 1'b0;
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else if (recover) begin
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign down       = st_q.down;
    assign down_pulse = st_q.pulse;

    // R4: a reference pulse on a healthy channel keeps it healthy next cycle
    a_r4_ref_keeps_alive: assert property (@(posedge clk) disable iff (!rst_n)
        (!down && ref_seen) |=> !down);
    // R5: the report pulse only accompanies a fresh failure and lasts one cycle
    a_r5_pulse_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(down) |-> down_pulse);
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        down_pulse |=> !down_pulse);
    a_r5_pulse_means_down: assert property (@(posedge clk) disable iff (!rst_n)
        down_pulse |-> down);
    // R9: without an earlier recovery request a downed channel stays down
    a_r9_no_silent_return: assert property (@(posedge clk) disable iff (!rst_n)
        (down && !st_q.armed) |=> down);

endmodule

// File: rtl/dld_router.sv
module dld_router
    import dld_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    input  logic             msg_urgent,
    input  logic [1:0]       link_ok,
    input  logic [1:0]       ch_ready,
    output logic             msg_ready,
    output logic [1:0]       ch_valid,
    output logic [CNT_W-1:0] drop_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             rr;
        logic [CNT_W-1:0] drops;
    } rt_state_t;

    rt_state_t st_d, st_q;
    route_e    route;

    // Route decision for the offered message.
    always_comb begin
        route = ROUTE_HOLD;
        if (msg_valid) begin
            unique case (link_ok)
                2'b11: begin
                    if (ch_ready[st_q.rr])       route = route_of(st_q.rr);
                    else if (ch_ready[~st_q.rr]) route = route_of(~st_q.rr);
                end
                2'b01, 2'b10: begin
                    if (!msg_urgent)                  route = ROUTE_DROP;
                    else if (ch_ready[link_ok[1]])    route = route_of(link_ok[1]);
                end
                default: route = ROUTE_DROP;
            endcase
        end
    end

    always_comb begin
        st_d = st_q;
        if (route == ROUTE_CH0) st_d.rr = 1'b1;
        if (route == ROUTE_CH1) st_d.rr = 1'b0;
        if (route == ROUTE_DROP && !msg_urgent && st_q.drops != CNT_MAX)
            st_d.drops = st_q.drops + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch_valid[0] = (route == ROUTE_CH0);
    assign ch_valid[1] = (route == ROUTE_CH1);
    assign msg_ready   = (route != ROUTE_HOLD);
    assign drop_count  = st_q.drops;

    // R6: never offer to a downed channel
    a_r6_no_dead_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid & ~link_ok) == 2'b00);
    // R3: at most one channel receives a message
    a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_valid));
    // R7: single-channel mode discards non-urgent traffic at once
    a_r7_shed: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(link_ok) == 1 && msg_valid && !msg_urgent) |-> (msg_ready && ch_valid == 2'b00));
    // R8: nothing leaves when both channels are down
    a_r8_total_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ok == 2'b00 && msg_valid) |-> (msg_ready && ch_valid == 2'b00));
    // R10: the drop tally never decreases
    a_r10_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> drop_count >= $past(drop_count));

endmodule

// File: rtl/dual_link_dispatch.sv
module dual_link_dispatch
    import dld_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TMR_W  = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  cfg_timeout,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  logic [DATA_W-1:0] msg_data,
    input  logic              msg_urgent,
    output logic [1:0]        ch_valid,
    input  logic [1:0]        ch_ready,
    output logic [DATA_W-1:0] ch0_data,
    output logic [DATA_W-1:0] ch1_data,
    input  logic [1:0]        ref_pulse,
    input  logic [1:0]        recover_req,
    output logic [1:0]        link_ok,
    output logic [1:0]        fail_pulse,
    output logic              total_fail,
    output logic [CNT_W-1:0]  drop_count
);

    localparam int N_CH = 2;

    logic [N_CH-1:0] down;

    for (genvar i = 0; i < N_CH; i++) begin : g_wd
        dld_watchdog #(.TMR_W(TMR_W)) u_wd (
            .clk        (clk),
            .rst_n      (rst_n),
            .limit      (cfg_timeout),
            .ref_seen   (ref_pulse[i]),
            .recover    (recover_req[i]),
            .down       (down[i]),
            .down_pulse (fail_pulse[i])
        );
    end

    assign link_ok    = ~down;
    assign total_fail = &down;

    dld_router #(.CNT_W(CNT_W)) u_rt (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_valid  (msg_valid),
        .msg_urgent (msg_urgent),
        .link_ok    (link_ok),
        .ch_ready   (ch_ready),
        .msg_ready  (msg_ready),
        .ch_valid   (ch_valid),
        .drop_count (drop_count)
    );

    assign ch0_data = msg_data;
    assign ch1_data = msg_data;

    // R8: total failure flag agrees with the per-channel health
    a_r8_total_flag: assert property (@(posedge clk) disable iff (!rst_n)
        total_fail |-> (link_ok == 2'b00 && ch_valid == 2'b00));

endmodule

// File: tb/sim_dual_link_dispatch.sv
`timescale 1ns/1ps
module sim_dual_link_dispatch;

    localparam int DW = 8;
    localparam int TW = 16;
    localparam int CW = 8;
    localparam int TMO = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] cfg_timeout = TW'(TMO);
    logic          msg_valid = 1'b0;
    logic          msg_ready;
    logic [DW-1:0] msg_data = '0;
    logic          msg_urgent = 1'b0;
    logic [1:0]    ch_valid;
    logic [1:0]    ch_ready = 2'b11;
    logic [DW-1:0] ch0_data, ch1_data;
    logic [1:0]    ref_pulse = 2'b00;
    logic [1:0]    recover_req = 2'b00;
    logic [1:0]    link_ok;
    logic [1:0]    fail_pulse;
    logic          total_fail;
    logic [CW-1:0] drop_count;

    always #10 clk = ~clk;  // 50 MHz

    dual_link_dispatch #(.DATA_W(DW), .TMR_W(TW), .CNT_W(CW)) u0 (
        .clk, .rst_n, .cfg_timeout, .msg_valid, .msg_ready, .msg_data, .msg_urgent,
        .ch_valid, .ch_ready, .ch0_data, .ch1_data, .ref_pulse, .recover_req,
        .link_ok, .fail_pulse, .total_fail, .drop_count
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- reference pulse generators ----------------
    bit [1:0] ref_en = 2'b11;
    int       ref_period [2] = '{4, 4};
    for (genvar c = 0; c < 2; c++) begin : g_ref
        initial begin
            int n = 0;
            forever begin
                @(negedge clk);
                if (ref_en[c] && n >= ref_period[c] - 1) begin
                    ref_pulse[c] = 1'b1;
                    n = 0;
                end else begin
                    ref_pulse[c] = 1'b0;
                    n++;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct { int ch; logic [DW-1:0] d; string req; } exp_t;
    exp_t exp_q[$];
    int   fail_seen [2] = '{0, 0};

    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (rst_n) begin
                for (int c = 0; c < 2; c++) if (fail_pulse[c]) fail_seen[c]++;
                if (msg_valid && msg_ready) begin
                    int act_ch;
                    logic [DW-1:0] act_d;
                    act_ch = 2;
                    act_d  = msg_data;
                    if (ch_valid[0] && ch_ready[0]) begin act_ch = 0; act_d = ch0_data; end
                    else if (ch_valid[1] && ch_ready[1]) begin act_ch = 1; act_d = ch1_data; end
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "scoreboard-empty", act_ch, -1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(act_ch == e.ch, e.req, act_ch, e.ch);
                        if (act_ch != 2) chk(act_d == e.d, "R11", int'(act_d), int'(e.d));
                    end
                end
            end
        end
    end

    // Driver: call at a negedge; returns at the negedge after acceptance.
    task automatic send(input logic [DW-1:0] d, input logic urg, input int exp_ch, input string req);
        exp_t e;
        e.ch = exp_ch; e.d = d; e.req = req;
        exp_q.push_back(e);
        msg_data   = d;
        msg_urgent = urg;
        msg_valid  = 1'b1;
        forever begin
            bit hs;
            #5;
            hs = msg_ready;
            @(negedge clk);
            if (hs) break;
        end
        msg_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        idle(3);
        rst_n = 1'b1;
        #5;
        // R1 reset state
        chk(link_ok == 2'b11, "R1", link_ok, 3);
        chk(!total_fail && fail_pulse == 2'b00, "R1", {total_fail, fail_pulse}, 0);
        chk(drop_count == 0, "R1", drop_count, 0);
        chk(ch_valid == 2'b00, "R1", ch_valid, 0);
        @(negedge clk);

        // R1/R2 alternation from channel 0
        send(8'h11, 1'b0, 0, "R1");
        send(8'h22, 1'b0, 1, "R2");
        send(8'h33, 1'b1, 0, "R2");
        send(8'h44, 1'b0, 1, "R2");

        // R3 skip a busy channel
        ch_ready = 2'b01;
        send(8'h55, 1'b0, 0, "R3");
        send(8'h66, 1'b0, 0, "R3");
        // R3 stall when neither is ready
        ch_ready   = 2'b00;
        msg_data   = 8'h77; msg_urgent = 1'b0; msg_valid = 1'b1;
        idle(2);
        #5;
        chk(!msg_ready, "R3", msg_ready, 0);
        chk(ch_valid == 2'b00, "R3", ch_valid, 0);
        @(negedge clk);
        msg_valid = 1'b0;
        ch_ready  = 2'b10;
        send(8'h77, 1'b0, 1, "R3");
        ch_ready = 2'b11;
        send(8'h88, 1'b0, 0, "R2");

        // R4 spacing exactly at the limit stays healthy
        ref_period[0] = TMO; ref_period[1] = TMO;
        idle(40);
        #5;
        chk(link_ok == 2'b11, "R4", link_ok, 3);
        chk(fail_seen[0] == 0 && fail_seen[1] == 0, "R4", fail_seen[0] + fail_seen[1], 0);
        @(negedge clk);
        ref_period[0] = 4; ref_period[1] = 4;

        // R4/R5 channel 1 goes silent
        ref_en[1] = 1'b0;
        idle(20);
        #5;
        chk(link_ok == 2'b01, "R4", link_ok, 1);
        chk(fail_seen[1] == 1, "R5", fail_seen[1], 1);
        chk(!total_fail, "R8", total_fail, 0);
        @(negedge clk);

        // R6/R7/R10 single channel
        send(8'hA1, 1'b1, 0, "R6");
        send(8'hA2, 1'b0, 2, "R7");
        send(8'hA3, 1'b0, 2, "R7");
        send(8'hA4, 1'b1, 0, "R6");
        #5;
        chk(drop_count == 2, "R10", drop_count, 2);
        @(negedge clk);
        // R6 urgent waits for the survivor, ignores the ready downed channel
        ch_ready = 2'b10;
        msg_data = 8'hA5; msg_urgent = 1'b1; msg_valid = 1'b1;
        idle(2);
        #5;
        chk(!msg_ready && ch_valid == 2'b00, "R6", {msg_ready, ch_valid}, 0);
        @(negedge clk);
        msg_valid = 1'b0;
        ch_ready  = 2'b11;
        send(8'hA5, 1'b1, 0, "R6");

        // R9 reference alone does not readmit
        ref_en[1] = 1'b1;
        idle(20);
        #5;
        chk(link_ok == 2'b01, "R9", link_ok, 1);
        @(negedge clk);
        recover_req[1] = 1'b1;
        @(negedge clk);
        recover_req[1] = 1'b0;
        idle(10);
        #5;
        chk(link_ok == 2'b11, "R9", link_ok, 3);
        chk(fail_seen[1] == 1, "R5", fail_seen[1], 1);
        @(negedge clk);

        // R8/R10 both channels down
        ref_en = 2'b00;
        idle(20);
        #5;
        chk(total_fail && link_ok == 2'b00, "R8", {total_fail, link_ok}, 4);
        chk(fail_seen[0] == 1 && fail_seen[1] == 2, "R5", fail_seen[0] * 10 + fail_seen[1], 12);
        @(negedge clk);
        send(8'hB1, 1'b1, 2, "R8");
        send(8'hB2, 1'b0, 2, "R8");
        #5;
        chk(drop_count == 3, "R10", drop_count, 3);
        chk(exp_q.size() == 0, "scoreboard-drain", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule